// File: doc/BRIEF.md
# Keyed Shutdown and Wake-Up Controller

This block holds a system's power-enable line and drops it when software asks for shutdown through a command write that carries a password byte. It runs entirely on the 32768 Hz slow clock. While the system is off, the block watches up to sixteen external wake pins and an RTC alarm line. When a qualified wake event arrives, it raises the power-enable line again and records what caused the wake.

Each wake pin has its own enable bit and its own active-level bit. All pins share one debounce setting, chosen from a fixed table of slow-clock counts. A pin qualifies only after it has held its active level for that many consecutive clock edges. The RTC alarm is not debounced, and it wakes the system only when its enable bit is set.

The behaviour is a two-state machine:
- State `ST_RUN` drives `pwr_en_n` high.
- State `ST_OFF` drives it low.
- Transition CMD_OK goes from `ST_RUN` to `ST_OFF` on a correctly keyed command write.
- Transition WAKE goes from `ST_OFF` back to `ST_RUN` on the first qualified pin or enabled alarm.
- The debouncer is armed only in `ST_OFF`.

Top module: `shdn_wake_ctrl`

## Requirements
- R1: A write to word 0 starts shutdown (`pwr_en_n` low after that edge) only when data bit 0 is 1 and bits 31:24 equal 0xA5; any other write to word 0 leaves `pwr_en_n` high.
- R2: After reset, `pwr_en_n` is high and words 1, 2 and 3 read as zero.
- R3: Word 1 holds the debounce code in bits 26:24 and the RTC-wake enable in bit 17; all its other bits read as zero.
- R4: Word 3 holds the pin enables in bits 15:0 (bit i for pin i) and the pin active levels in bits 31:16 (bit 16+i for pin i, 1 = active high, 0 = active low). It reads back exactly as written.
- R5: Debounce codes 0..5 select 0, 3, 32, 512, 4096 and 32768 cycles, and codes 6 and 7 select 32768. With a count N > 0, the wake occurs at the Nth consecutive edge that samples the pin active, and any edge that samples it inactive restarts the count. Code 0 wakes at the first edge that samples it active.
- R6: A pin whose enable bit is 0, or a pin held at its inactive level, never ends shutdown.
- R7: While off, an edge that samples the RTC alarm high wakes the block if and only if word 1 bit 17 is set at that edge.
- R8: In the running state, wake pins and the alarm change neither `pwr_en_n` nor the status word.
- R9: Word 2 (status) is loaded only at the waking edge. Bits 31:16 flag the enabled pins that were qualified at that edge (bit 16+i for pin i), bit 5 flags an enabled alarm, and all other bits are 0.
- R10: A read of word 2 returns the status and clears it at that edge, so an immediate second read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (read of word 2 clears status) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| wake_pins | input | 16 | External wake-up pins |
| rtc_alarm | input | 1 | RTC alarm level |
| pwr_en_n | output | 1 | High while running, low while shut down |

## Verification
Register writes take effect at the edge that samples the strobe, and `pwr_en_n` falls at that same edge for a keyed command. Read data is combinational, so the bench samples `bus_rdata` inside the strobed cycle before the edge, and that edge performs the status clear. A wake is due at the edge that samples an enabled alarm, or at edge max(N,1) counted from the first edge that samples a pin active. The bench drives inputs at the falling edge and counts rising edges until `pwr_en_n` rises, then compares that count with its own table of debounce lengths. Status is read right after the waking edge.

// File: rtl/shdn_pkg.sv
package shdn_pkg;

    typedef enum logic [0:0] {
        ST_RUN = 1'b0,
        ST_OFF = 1'b1
    } shdn_state_t;

    localparam logic [7:0] CMD_KEY   = 8'hA5;
    localparam int         DBC_CNT_W = 16;

    localparam logic [3:0] W_CTRL = 4'd0;
    localparam logic [3:0] W_MODE = 4'd1;
    localparam logic [3:0] W_STAT = 4'd2;
    localparam logic [3:0] W_WAKE = 4'd3;

    function automatic logic [DBC_CNT_W-1:0] dbc_len(input logic [2:0] code);
        logic [DBC_CNT_W-1:0] len;
        unique case (code)
            3'd0:    len = '0;
            3'd1:    len = DBC_CNT_W'(3);
            3'd2:    len = DBC_CNT_W'(32);
            3'd3:    len = DBC_CNT_W'(512);
            3'd4:    len = DBC_CNT_W'(4096);
            default: len = DBC_CNT_W'(32768);
        endcase
        return len;
    endfunction

endpackage

// File: rtl/shdn_regs.sv
module shdn_regs
    import shdn_pkg::*;
#(
    parameter int NUM_WAKE = 16,
    parameter int AW       = 4,
    parameter int DW       = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                re,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    input  logic                wake_evt,
    input  logic [NUM_WAKE-1:0] pin_hit,
    input  logic                rtc_hit,
    output logic                cmd_ok,
    output logic [2:0]          dbc_code,
    output logic                rtc_en,
    output logic [NUM_WAKE-1:0] pin_en,
    output logic [NUM_WAKE-1:0] pin_pol,
    output logic [DW-1:0]       status
);

    localparam int POL_LSB  = 16;
    localparam int DBC_LSB  = 24;
    localparam int RTCE_BIT = 17;
    localparam int RTCS_BIT = 5;

    logic hit_ctrl, hit_mode, hit_stat, hit_wake;

    always_comb begin
        hit_ctrl = (addr == AW'(W_CTRL));
        hit_mode = (addr == AW'(W_MODE));
        hit_stat = (addr == AW'(W_STAT));
        hit_wake = (addr == AW'(W_WAKE));
    end

    assign cmd_ok = we && hit_ctrl && wdata[0] && (wdata[DW-1 -: 8] == CMD_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbc_code <= '0;
            rtc_en   <= 1'b0;
        end else if (we && hit_mode) begin
            dbc_code <= wdata[DBC_LSB +: 3];
            rtc_en   <= wdata[RTCE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_en  <= '0;
            pin_pol <= '0;
        end else if (we && hit_wake) begin
            pin_en  <= wdata[NUM_WAKE-1:0];
            pin_pol <= wdata[POL_LSB +: NUM_WAKE];
        end
    end

    // the waking edge wins over a simultaneous clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else if (wake_evt) begin
            status                         <= '0;
            status[POL_LSB +: NUM_WAKE]    <= pin_hit;
            status[RTCS_BIT]               <= rtc_hit;
        end else if (re && hit_stat) begin
            status <= '0;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_mode) begin
            rdata[DBC_LSB +: 3] = dbc_code;
            rdata[RTCE_BIT]     = rtc_en;
        end else if (hit_stat) begin
            rdata = status;
        end else if (hit_wake) begin
            rdata[NUM_WAKE-1:0]         = pin_en;
            rdata[POL_LSB +: NUM_WAKE]  = pin_pol;
        end
    end

endmodule

// File: rtl/shdn_debounce.sv
module shdn_debounce
    import shdn_pkg::*;
#(
    parameter int NUM_WAKE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic [2:0]          code,
    input  logic [NUM_WAKE-1:0] pins,
    input  logic [NUM_WAKE-1:0] en,
    input  logic [NUM_WAKE-1:0] pol,
    output logic [NUM_WAKE-1:0] qual
);

    logic [DBC_CNT_W-1:0] len;
    logic [DBC_CNT_W-1:0] target;

    always_comb begin
        len    = dbc_len(code);
        target = (len == '0) ? '0 : len - 1'b1;
    end

    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_pin
        logic                 active;
        logic [DBC_CNT_W-1:0] cnt;

        assign active = en[i] && (pins[i] == pol[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (!arm || !active) begin
                cnt <= '0;
            end else if (cnt != target) begin
                cnt <= cnt + 1'b1;
            end
        end

        assign qual[i] = arm && active && (cnt == target);
    end

endmodule

// File: rtl/shdn_fsm.sv
module shdn_fsm
    import shdn_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_ok,
    input  logic        wake_any,
    output shdn_state_t state,
    output logic        pwr_en_n,
    output logic        arm,
    output logic        wake_evt
);

    shdn_state_t state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN: if (cmd_ok)   state_d = ST_OFF;
            ST_OFF: if (wake_any) state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_d;
    end

    always_comb begin
        pwr_en_n = 1'b1;
        arm      = 1'b0;
        wake_evt = 1'b0;
        unique case (state)
            ST_RUN: pwr_en_n = 1'b1;
            ST_OFF: begin
                pwr_en_n = 1'b0;
                arm      = 1'b1;
                wake_evt = wake_any;
            end
        endcase
    end

endmodule

// File: rtl/shdn_wake_ctrl.sv
module shdn_wake_ctrl
    import shdn_pkg::*;
#(
    parameter int NUM_WAKE = 16,
    parameter int AW       = 4,
    parameter int DW       = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NUM_WAKE-1:0] wake_pins,
    input  logic                rtc_alarm,
    output logic                pwr_en_n
);

    shdn_state_t         state;
    logic                cmd_ok, arm, wake_evt, wake_any;
    logic [2:0]          dbc_code;
    logic                rtc_en, rtc_hit;
    logic [NUM_WAKE-1:0] pin_en, pin_pol, pin_qual;
    logic [DW-1:0]       status_q;

    assign rtc_hit  = rtc_en && rtc_alarm;
    assign wake_any = (|pin_qual) || rtc_hit;

    shdn_regs #(.NUM_WAKE(NUM_WAKE), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .re       (bus_re),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .wake_evt (wake_evt),
        .pin_hit  (pin_qual),
        .rtc_hit  (rtc_hit),
        .cmd_ok   (cmd_ok),
        .dbc_code (dbc_code),
        .rtc_en   (rtc_en),
        .pin_en   (pin_en),
        .pin_pol  (pin_pol),
        .status   (status_q)
    );

    shdn_debounce #(.NUM_WAKE(NUM_WAKE)) u_dbc (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .code  (dbc_code),
        .pins  (wake_pins),
        .en    (pin_en),
        .pol   (pin_pol),
        .qual  (pin_qual)
    );

    shdn_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_ok   (cmd_ok),
        .wake_any (wake_any),
        .state    (state),
        .pwr_en_n (pwr_en_n),
        .arm      (arm),
        .wake_evt (wake_evt)
    );

endmodule

// File: rtl/shdn_wake_ctrl_chk.sv
module shdn_wake_ctrl_chk #(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic          bus_re,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          rtc_alarm,
    input logic          rtc_en,
    input logic          pwr_en_n,
    input logic [DW-1:0] status_q
);

    logic key_good, ctrl_wr;
    assign ctrl_wr  = bus_we && (bus_addr == AW'(0));
    assign key_good = bus_wdata[0] && (bus_wdata[DW-1 -: 8] == 8'hA5);

    p_key_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en_n && ctrl_wr && key_good) |=> !pwr_en_n);

    p_key_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en_n && ctrl_wr && !key_good) |=> pwr_en_n);

    p_rtc_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en_n && rtc_en && rtc_alarm) |=> pwr_en_n);

    p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en_n && !ctrl_wr) |=> pwr_en_n);

    p_status_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en_n && !(bus_re && bus_addr == AW'(2))) |=> $stable(status_q));

    p_status_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_n) |-> (status_q != '0));

    p_status_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en_n && bus_re && bus_addr == AW'(2)) |=> (status_q == '0));

endmodule

bind shdn_wake_ctrl shdn_wake_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rtc_alarm (rtc_alarm),
    .rtc_en    (rtc_en),
    .pwr_en_n  (pwr_en_n),
    .status_q  (status_q)
);

// File: tb/shdn_wake_ctrl_tb.sv
module shdn_wake_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] wake_pins = '0;
    logic        rtc_alarm = 1'b0;
    logic        pwr_en_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    shdn_wake_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wake_pins (wake_pins),
        .rtc_alarm (rtc_alarm),
        .pwr_en_n  (pwr_en_n)
    );

    function automatic int exp_len(input int code);
        case (code)
            0:       return 1;
            1:       return 3;
            2:       return 32;
            3:       return 512;
            4:       return 4096;
            default: return 32768;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        tick();
        bus_re = 1'b0;
    endtask

    task automatic count_wake(input int lim, output int k);
        k = 0;
        while (pwr_en_n == 1'b0 && k < lim) begin
            tick();
            k++;
        end
    endtask

    // one pin wake with a given code; checks cycle count and status
    task automatic pin_wake(input int code, input int j, input logic [15:0] en, input logic [15:0] pol);
        logic [31:0] d;
        int k;
        logic [15:0] e2;
        e2 = en; e2[j] = 1'b1;
        wake_pins = ~pol;
        wr(4'd1, {5'b0, code[2:0], 24'b0});
        wr(4'd3, {pol, e2});
        wr(4'd0, 32'hA500_0001);
        chk(pwr_en_n == 1'b0, "R1 keyed shutdown", {31'b0, pwr_en_n}, 32'h0);
        wake_pins[j] = pol[j];
        count_wake(exp_len(code) + 8, k);
        chk(k == exp_len(code), $sformatf("R5 code %0d wake edges", code), k, exp_len(code));
        rd(4'd2, d);
        chk(d == (32'h1 << (16 + j)), "R9 pin status", d, 32'h1 << (16 + j));
        wake_pins = ~pol;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int k;
        int unsigned seed;
        seed = $urandom(32'd2024);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk(pwr_en_n == 1'b1, "R2 pwr_en_n after reset", {31'b0, pwr_en_n}, 32'h1);
        rd(4'd1, d); chk(d == 32'h0, "R2 mode reset", d, 32'h0);
        rd(4'd3, d); chk(d == 32'h0, "R2 wake reg reset", d, 32'h0);
        rd(4'd2, d); chk(d == 32'h0, "R2 status reset", d, 32'h0);

        // R3 mode field layout
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, d); chk(d == 32'h0702_0000, "R3 mode readback", d, 32'h0702_0000);
        wr(4'd1, 32'h0);

        // R4 wake reg readback
        wr(4'd3, 32'h1234_ABCD);
        rd(4'd3, d); chk(d == 32'h1234_ABCD, "R4 wake reg readback", d, 32'h1234_ABCD);
        wr(4'd3, 32'h0);

        // R1 rejected commands
        wr(4'd0, 32'hA400_0001);
        chk(pwr_en_n == 1'b1, "R1 wrong key ignored", {31'b0, pwr_en_n}, 32'h1);
        wr(4'd0, 32'hA500_0000);
        chk(pwr_en_n == 1'b1, "R1 bit0 clear ignored", {31'b0, pwr_en_n}, 32'h1);
        wr(4'd0, 32'h0000_0001);
        chk(pwr_en_n == 1'b1, "R1 no key ignored", {31'b0, pwr_en_n}, 32'h1);

        // R8 running state ignores wake sources
        wr(4'd1, 32'h0002_0000);
        wr(4'd3, 32'hFFFF_FFFF);
        wake_pins = 16'hFFFF; rtc_alarm = 1'b1;
        repeat (5) tick();
        chk(pwr_en_n == 1'b1, "R8 running unaffected", {31'b0, pwr_en_n}, 32'h1);
        rd(4'd2, d); chk(d == 32'h0, "R8 status untouched", d, 32'h0);
        rtc_alarm = 1'b0; wake_pins = '0;
        wr(4'd3, 32'h0); wr(4'd1, 32'h0);

        // R5 debounce lengths, directed, including clamp code 7
        pin_wake(0, 3, 16'h0, 16'hFFFF);
        pin_wake(1, 9, 16'h0, 16'h0000);
        pin_wake(3, 0, 16'h0, 16'h0001);
        pin_wake(4, 15, 16'h0, 16'h8000);
        pin_wake(5, 6, 16'h0, 16'h0000);
        pin_wake(7, 12, 16'h0, 16'h1000);

        // R5 glitch restarts the count
        wake_pins = 16'h0;
        wr(4'd1, 32'h0100_0000);
        wr(4'd3, 32'h0004_0004);
        wr(4'd0, 32'hA500_0001);
        wake_pins[2] = 1'b1; tick(); tick();
        wake_pins[2] = 1'b0; tick();
        chk(pwr_en_n == 1'b0, "R5 glitch prevents wake", {31'b0, pwr_en_n}, 32'h0);
        wake_pins[2] = 1'b1;
        count_wake(20, k);
        chk(k == 3, "R5 count restarts after glitch", k, 3);
        rd(4'd2, d);
        wake_pins = '0;

        // R6 disabled pin and inactive level do not wake
        wake_pins = 16'h0010;
        wr(4'd1, 32'h0);
        wr(4'd3, 32'h0000_0010);
        wr(4'd0, 32'hA500_0001);
        for (int i = 0; i < 6; i++) begin
            wake_pins[7] = i[0];
            tick();
        end
        chk(pwr_en_n == 1'b0, "R6 disabled/inactive no wake", {31'b0, pwr_en_n}, 32'h0);
        wake_pins[4] = 1'b0;
        count_wake(5, k);
        chk(k == 1, "R6 enabled active-low pin wakes", k, 1);
        rd(4'd2, d); chk(d == 32'h0010_0000, "R9 status for pin4", d, 32'h0010_0000);
        // R10 second read sees cleared status
        rd(4'd2, d); chk(d == 32'h0, "R10 status cleared by read", d, 32'h0);

        // R7 alarm needs its enable
        wake_pins = '0;
        wr(4'd3, 32'h0);
        wr(4'd0, 32'hA500_0001);
        rtc_alarm = 1'b1;
        repeat (3) tick();
        chk(pwr_en_n == 1'b0, "R7 disabled alarm ignored", {31'b0, pwr_en_n}, 32'h0);
        wr(4'd1, 32'h0002_0000);
        chk(pwr_en_n == 1'b0, "R7 enable takes effect next edge", {31'b0, pwr_en_n}, 32'h0);
        tick();
        chk(pwr_en_n == 1'b1, "R7 enabled alarm wakes", {31'b0, pwr_en_n}, 32'h1);
        rd(4'd2, d); chk(d == 32'h0000_0020, "R9 alarm status", d, 32'h20);
        rtc_alarm = 1'b0;

        // R9 pin and alarm on the same edge
        wake_pins = '0;
        wr(4'd3, 32'h0002_0002);
        wr(4'd0, 32'hA500_0001);
        wake_pins[1] = 1'b1; rtc_alarm = 1'b1;
        tick();
        chk(pwr_en_n == 1'b1, "R9 joint wake", {31'b0, pwr_en_n}, 32'h1);
        rd(4'd2, d); chk(d == 32'h0002_0020, "R9 joint status", d, 32'h0002_0020);
        rtc_alarm = 1'b0; wake_pins = '0;
        wr(4'd1, 32'h0);

        // constrained random rounds (R5, R9)
        for (int r = 0; r < 24; r++) begin
            logic [15:0] en, pol;
            int j, code;
            en   = 16'($urandom);
            pol  = 16'($urandom);
            j    = int'($urandom % 16);
            code = int'($urandom % 3);
            pin_wake(code, j, en, pol);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule